// File: doc/BRIEF.md
# Dual Halfword Exchange Saturating Adder

This block takes two 32-bit operands, N and M, and treats each as a pair of 16-bit lanes. The lanes are crossed: the low lane of N pairs with the high lane of M, and the high lane of N pairs with the low lane of M. One pair is added and the other is subtracted. A direction select decides which pair gets which operation. Each lane result is then clamped to 16 bits, in either a signed or an unsigned number system.

The two clamped lanes are packed into one 32-bit result. In the default build that result is registered, so it appears one clock after the inputs. A condition-pass input gates the write. When it is low, the result register keeps its old value and the write-enable output stays low. The block produces no saturation flag of any kind. A sticky flag kept elsewhere is therefore never changed by it.

Top module: `hxsat_xchg_unit`

## Requirements
- R1: With `dir_sax` = 0 (add-high mode), the low result lane is N[15:0] minus M[31:16] and the high result lane is N[31:16] plus M[15:0].
- R2: With `dir_sax` = 1 (add-low mode), the low result lane is N[15:0] plus M[31:16] and the high result lane is N[31:16] minus M[15:0].
- R3: With `is_unsigned` = 0, every lane is sign-extended before the operation. The lane result clamps to the range -32768 (0x8000) to 32767 (0x7FFF).
- R4: With `is_unsigned` = 1, every lane is zero-extended before the operation. A negative lane result becomes 0x0000, and a lane result above 65535 becomes 0xFFFF.
- R5: The low lane result sits in `res[15:0]` and the high lane result in `res[31:16]`. Saturation in one lane leaves the other lane's value unchanged.
- R6: When `cond_pass` is 1 at a rising clock edge, `res` shows the new result and `res_we` is 1 after that edge.
- R7: When `cond_pass` is 0 at a rising clock edge, `res_we` is 0 after that edge and `res` keeps its previous value, whatever the operands are.
- R8: While `rst_n` is low, `res` is 0 and `res_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_n | input | 32 | Operand N, two 16-bit lanes |
| op_m | input | 32 | Operand M, two 16-bit lanes, crossed against N |
| dir_sax | input | 1 | 0: low lane subtracts, high lane adds; 1: the reverse |
| is_unsigned | input | 1 | 0: signed clamp; 1: unsigned clamp |
| cond_pass | input | 1 | Write gate for the result |
| res | output | 32 | Packed clamped result |
| res_we | output | 1 | High for one cycle after a passed operation |

## Verification
The bound checker runs on every cycle and covers these behaviours:
- the write gate: a passed operation raises `res_we`, and a blocked one holds `res` and lowers `res_we`;
- the direction of saturation in unsigned add-high mode: the high sum never falls below N's high lane, and the low difference never exceeds N's low lane;
- in signed add-high mode, a sum of two non-negative lanes never turns negative.

Only the bench scenarios can show the following:
- the exact lane values for each mode and direction pairing;
- the exact clamp points at 0x7FFF, 0x8000, 0x0000 and 0xFFFF;
- the crossing of lanes;
- that saturation in one lane leaves the other lane's value unchanged;
- the reset values.

// File: rtl/hxsat_pkg.sv
package hxsat_pkg;

   // Which crossed pair is added.
   //   XCH_ADD_HI: the high result lane adds, the low result lane subtracts.
   //   XCH_ADD_LO: the low result lane adds, the high result lane subtracts.
   typedef enum logic {
      XCH_ADD_HI = 1'b0,
      XCH_ADD_LO = 1'b1
   } xch_dir_e;

   // The exchange always pairs exactly two lanes.
   localparam int unsigned HXSAT_LANES = 2;

endpackage

// File: rtl/hxsat_extend.sv
// Widens one lane to the arithmetic width.
// Zero fill in unsigned mode, sign fill in signed mode.
module hxsat_extend #(
   parameter int LANE_W = 16,
   parameter int EXT_W  = LANE_W + 2
) (
   input  logic [LANE_W-1:0]       lane,
   input  logic                    uns,
   output logic signed [EXT_W-1:0] ext
);
   localparam int PAD_W = EXT_W - LANE_W;

   if (PAD_W < 2) begin : g_bad_width
      $error("hxsat_extend: EXT_W must exceed LANE_W by at least two bits");
   end

   logic fill;

   always_comb begin
      fill = uns ? 1'b0 : lane[LANE_W-1];
      ext  = {{PAD_W{fill}}, lane};
   end

endmodule

// File: rtl/hxsat_addsub.sv
// Exact add or subtract of two extended lanes. No rounding, no clamping.
module hxsat_addsub #(
   parameter int EXT_W = 18
) (
   input  logic signed [EXT_W-1:0] a,
   input  logic signed [EXT_W-1:0] b,
   input  logic                    sub,
   output logic signed [EXT_W-1:0] y
);

   if (EXT_W < 3) begin : g_bad_width
      $error("hxsat_addsub: EXT_W too small");
   end

   always_comb begin
      if (sub) y = a - b;
      else     y = a + b;
   end

endmodule

// File: rtl/hxsat_clamp.sv
// Clamps an exact wide value into a LANE_W-bit signed or unsigned range.
module hxsat_clamp #(
   parameter int LANE_W = 16,
   parameter int EXT_W  = LANE_W + 2
) (
   input  logic signed [EXT_W-1:0] val,
   input  logic                    uns,
   output logic [LANE_W-1:0]       lane
);
   localparam int HEAD_W = EXT_W - LANE_W;

   if (HEAD_W < 2) begin : g_bad_width
      $error("hxsat_clamp: EXT_W must exceed LANE_W by at least two bits");
   end

   // Range limits, written at the full arithmetic width.
   localparam logic signed [EXT_W-1:0] S_MAX = {{(HEAD_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] S_MIN = {{(HEAD_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
   localparam logic signed [EXT_W-1:0] U_MAX = {{HEAD_W{1'b0}}, {LANE_W{1'b1}}};

   localparam logic [LANE_W-1:0] L_SMAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] L_SMIN = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] L_UMAX = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] L_ZERO = '0;

   logic over_s, under_s, over_u, under_u;

   always_comb begin
      over_s  = val > S_MAX;
      under_s = val < S_MIN;
      over_u  = val > U_MAX;
      under_u = val[EXT_W-1];
      if (uns) begin
         if (under_u)     lane = L_ZERO;
         else if (over_u) lane = L_UMAX;
         else             lane = val[LANE_W-1:0];
      end else begin
         if (under_s)     lane = L_SMIN;
         else if (over_s) lane = L_SMAX;
         else             lane = val[LANE_W-1:0];
      end
   end

endmodule

// File: rtl/hxsat_xchg_unit.sv
// Crossed-lane saturating add/subtract with a gated output register.
module hxsat_xchg_unit
   import hxsat_pkg::*;
#(
   parameter int LANE_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*LANE_W-1:0]   op_n,
   input  logic [2*LANE_W-1:0]   op_m,
   input  logic                  dir_sax,
   input  logic                  is_unsigned,
   input  logic                  cond_pass,
   output logic [2*LANE_W-1:0]   res,
   output logic                  res_we
);
   localparam int WORD_W = int'(HXSAT_LANES) * LANE_W;
   localparam int EXT_W  = LANE_W + 2;

   if (LANE_W < 2) begin : g_bad_lane
      $error("hxsat_xchg_unit: LANE_W must be at least 2");
   end

   xch_dir_e            dir;
   logic [WORD_W-1:0]   packed_res;

   assign dir = xch_dir_e'(dir_sax);

   for (genvar g = 0; g < int'(HXSAT_LANES); g++) begin : g_lane
      // Crossing: lane g of N meets the opposite lane of M.
      localparam int PEER = int'(HXSAT_LANES) - 1 - g;

      logic signed [EXT_W-1:0] a_ext, b_ext, raw;
      logic                    do_sub;
      logic [LANE_W-1:0]       clamped;

      if (g == 0) begin : g_lo_op
         assign do_sub = (dir == XCH_ADD_HI);
      end else begin : g_hi_op
         assign do_sub = (dir == XCH_ADD_LO);
      end

      hxsat_extend #(.LANE_W(LANE_W), .EXT_W(EXT_W)) u_ext_n (
         .lane (op_n[g*LANE_W +: LANE_W]),
         .uns  (is_unsigned),
         .ext  (a_ext)
      );

      hxsat_extend #(.LANE_W(LANE_W), .EXT_W(EXT_W)) u_ext_m (
         .lane (op_m[PEER*LANE_W +: LANE_W]),
         .uns  (is_unsigned),
         .ext  (b_ext)
      );

      hxsat_addsub #(.EXT_W(EXT_W)) u_arith (
         .a   (a_ext),
         .b   (b_ext),
         .sub (do_sub),
         .y   (raw)
      );

      hxsat_clamp #(.LANE_W(LANE_W), .EXT_W(EXT_W)) u_clamp (
         .val  (raw),
         .uns  (is_unsigned),
         .lane (clamped)
      );

      assign packed_res[g*LANE_W +: LANE_W] = clamped;
   end

   if (REG_OUT) begin : g_reg_out
      logic [WORD_W-1:0] res_q;
      logic              we_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
            we_q  <= 1'b0;
         end else begin
            we_q <= cond_pass;
            if (cond_pass) res_q <= packed_res;
         end
      end

      assign res    = res_q;
      assign res_we = we_q;
   end else begin : g_comb_out
      assign res    = packed_res;
      assign res_we = cond_pass;
   end

endmodule

// File: rtl/hxsat_checker.sv
// Checker for the registered build, attached to the top module by bind.
module hxsat_checker #(
   parameter int LANE_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2*LANE_W-1:0] op_n,
   input logic [2*LANE_W-1:0] op_m,
   input logic                dir_sax,
   input logic                is_unsigned,
   input logic                cond_pass,
   input logic [2*LANE_W-1:0] res,
   input logic                res_we
);
   localparam int HI = LANE_W;

   if (REG_OUT) begin : g_chk
      // R6: a passed operation raises the write-enable on the next edge.
      p_we_follows_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cond_pass |=> res_we);

      // R7: a blocked operation keeps the result and lowers the write-enable.
      p_hold_when_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !cond_pass |=> (!res_we && $stable(res)));

      // R4: in unsigned add-high mode, the high sum never drops below N's high lane.
      p_uns_sum_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_pass && is_unsigned && !dir_sax)
         |=> (res[2*LANE_W-1:HI] >= $past(op_n[2*LANE_W-1:HI])));

      // R4: in unsigned add-high mode, the low difference never exceeds N's low lane.
      p_uns_diff_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_pass && is_unsigned && !dir_sax)
         |=> (res[LANE_W-1:0] <= $past(op_n[LANE_W-1:0])));

      // R3: in signed add-high mode, two non-negative lanes never give a negative sum.
      p_sgn_sum_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_pass && !is_unsigned && !dir_sax
          && !op_n[2*LANE_W-1] && !op_m[LANE_W-1])
         |=> !res[2*LANE_W-1]);
   end else begin : g_no_chk
      // The combinational build has no timing to check; the inputs are unused here.
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, op_n, op_m, dir_sax, is_unsigned,
                           cond_pass, res, res_we};
   end

endmodule

bind hxsat_xchg_unit hxsat_checker #(.LANE_W(LANE_W), .REG_OUT(REG_OUT)) u_hxsat_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_n        (op_n),
   .op_m        (op_m),
   .dir_sax     (dir_sax),
   .is_unsigned (is_unsigned),
   .cond_pass   (cond_pass),
   .res         (res),
   .res_we      (res_we)
);

// File: tb/tb_hxsat_xchg_unit.sv
`timescale 1ns/1ps
module tb_hxsat_xchg_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] op_n, op_m;
   logic        dir_sax, is_unsigned, cond_pass;
   logic [31:0] res;
   logic        res_we;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hxsat_xchg_unit dut (
      .clk(clk), .rst_n(rst_n), .op_n(op_n), .op_m(op_m),
      .dir_sax(dir_sax), .is_unsigned(is_unsigned), .cond_pass(cond_pass),
      .res(res), .res_we(res_we)
   );

   typedef struct packed {
      logic [31:0] n;
      logic [31:0] m;
      logic        dir;
      logic        uns;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{32'h0005_0003, 32'h0001_0002, 1'b0, 1'b0, 32'h0007_0002}, // R1 plain
      '{32'h0005_0003, 32'h0001_0002, 1'b1, 1'b0, 32'h0003_0004}, // R2 plain
      '{32'h7FFF_0000, 32'h0001_0001, 1'b0, 1'b0, 32'h7FFF_FFFF}, // R3 top clamp
      '{32'h0000_8000, 32'h0001_0000, 1'b0, 1'b0, 32'h0000_8000}, // R3 bottom clamp
      '{32'h8000_7FFF, 32'h7FFF_7FFF, 1'b1, 1'b0, 32'h8000_7FFF}, // R3 both lanes
      '{32'h0005_0003, 32'h0001_0002, 1'b0, 1'b1, 32'h0007_0002}, // R4 plain
      '{32'hFFFF_0001, 32'h0002_0002, 1'b0, 1'b1, 32'hFFFF_0000}, // R4 both clamps
      '{32'h0003_8000, 32'h8000_0004, 1'b1, 1'b1, 32'h0000_FFFF}, // R4 add-low clamps
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hFFFE_0000}, // R3 sign extension
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_0000}, // R4 zero extension
      '{32'h1234_0010, 32'h0020_0004, 1'b1, 1'b0, 32'h1230_0030}, // R2 crossing
      '{32'hFFFE_0002, 32'h0002_0001, 1'b0, 1'b1, 32'hFFFF_0000}, // R4 exact edges
      '{32'h7FFF_0100, 32'h0001_0100, 1'b0, 1'b0, 32'h7FFF_00FF}  // R5 lane independence
   };

   function automatic string tag_of(int i);
      case (i)
         0:             return "R1";
         1, 10:         return "R2";
         2, 3, 4, 8:    return "R3";
         12:            return "R5";
         default:       return "R4";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Watchdog: an expired run counts as one failed check.
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n       = 1'b0;
      op_n        = 32'hDEAD_BEEF;
      op_m        = 32'h1234_5678;
      dir_sax     = 1'b0;
      is_unsigned = 1'b0;
      cond_pass   = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset values, even with a passed operation at the inputs.
      chk("R8 res", res, 32'h0);
      chk("R8 res_we", {31'h0, res_we}, 32'h1 & 32'h0);
      rst_n = 1'b1;

      // Table walk: drive on a falling edge, check after the next rising edge.
      for (int i = 0; i < NV; i++) begin
         op_n        = VEC[i].n;
         op_m        = VEC[i].m;
         dir_sax     = VEC[i].dir;
         is_unsigned = VEC[i].uns;
         cond_pass   = 1'b1;
         @(negedge clk);
         chk(tag_of(i), res, VEC[i].exp);
         if (i == 0) chk("R6 res_we", {31'h0, res_we}, 32'h1);
      end

      // R7: blocked operation with operands that would give a new value.
      op_n        = 32'h0005_0003;
      op_m        = 32'h0001_0002;
      dir_sax     = 1'b0;
      is_unsigned = 1'b0;
      cond_pass   = 1'b0;
      @(negedge clk);
      chk("R7 res held", res, 32'h7FFF_00FF);
      chk("R7 res_we low", {31'h0, res_we}, 32'h0);
      op_n = 32'hAAAA_5555;
      @(negedge clk);
      chk("R7 res still held", res, 32'h7FFF_00FF);

      // R6: passing again writes the result and raises the write-enable.
      op_n      = 32'h0005_0003;
      cond_pass = 1'b1;
      @(negedge clk);
      chk("R6 res written", res, 32'h0007_0002);
      chk("R6 res_we high", {31'h0, res_we}, 32'h1);

      done = 1'b1;
      finish_run();
   end

endmodule